// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block merges thirty-two peripheral interrupt lines into one request toward a processor. Software works through a small register port with three words: an enable mask, a status view of every source, and a dispatch vector. The request output is high whenever any source is both raised in status and enabled in the mask. The vector word names the lowest-numbered such source, so an interrupt handler can branch straight to it without scanning bits.

Most status bits are plain live copies of their source lines and cannot be changed from software. Two positions, 10 and 11, belong to the serial-port transmit-done and receive-done events. Those events are short, so these two bits capture a rising edge and hold it until software writes a one to the bit. Writes use a single-cycle strobe. Reads use a single-cycle strobe, and the read data is registered, so it is valid one clock after the strobe. Between reads the read data holds its last value.

Top module: `pirq_aggregator`

## Requirements
- R1: After reset the mask word reads 0, status bits 10 and 11 read 0, the vector word reads 0 and `irq_o` is low.
- R2: A write to address 0x0 loads the whole mask word. A read of address 0x0 returns the stored mask in the cycle after the read strobe.
- R3: `irq_o` is high exactly when the AND of status and mask has at least one bit set. For live sources, `irq_o` follows the source level in the same cycle.
- R4: Status bit 10 sets on a rising edge of `src_i[10]`, and status bit 11 sets on a rising edge of `src_i[11]`. Each stays set after its source falls, and it clears only when a one is written to that bit at address 0x4. A source held high does not set the bit again after a clear.
- R5: Writing a zero to bit 10 or 11 at address 0x4 leaves that bit unchanged. When a rising edge and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R6: Every status bit other than 10 and 11 reads back the current level of its source line. Writes to address 0x4 have no effect on these bits.
- R7: A read of address 0x8 returns the vector word. Bit 31 is 1 when any source is pending, and bits 4:0 then hold the index of the lowest-numbered pending source. All other bits are 0, and the whole word is 0 when nothing is pending.
- R8: A source whose mask bit is 0 does not raise `irq_o` and does not appear in the vector word, whatever its status.
- R9: A read of any address other than 0x0, 0x4 and 0x8 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| src_i | input | 32 | Interrupt source levels, one per bit |
| reg_wr_i | input | 1 | Single-cycle write strobe |
| reg_rd_i | input | 1 | Single-cycle read strobe |
| reg_addr_i | input | 4 | Byte address of the register word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data, valid the cycle after `reg_rd_i` |
| irq_o | output | 1 | Aggregated interrupt request |

## Verification
The block holds state in three places: the mask word, the two latched event bits, and the previous-level flops that detect edges on those two bits. A wrong mask bit shows on `irq_o` and in the vector word as soon as its source rises, and it shows on the next mask read. A latched bit that is wrong is visible in `irq_o` on the clock after the wrong edge or clear. A missed or extra edge detection appears one status read later, as a bit that fails to set or fails to stay cleared while its source is held high. A faulty priority choice shows only when two or more enabled sources are pending together, so the sweeps place many such mixtures on the sources.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // Register word addresses (byte addressed, word aligned)
  localparam int unsigned ADDR_MASK   = 'h0;
  localparam int unsigned ADDR_STATUS = 'h4;
  localparam int unsigned ADDR_VECTOR = 'h8;

  // Default layout of the source vector
  localparam int unsigned DEF_NUM_SRC = 32;
  localparam logic [31:0] DEF_LATCHED = 32'h0000_0C00;

  typedef enum logic [1:0] {
    SEL_MASK,
    SEL_STATUS,
    SEL_VECTOR,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/pirq_mask_reg.sv
module pirq_mask_reg #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (wr_i) begin
      mask_q <= wdata_i;
    end
  end

  assign mask_o = mask_q;

  AST_MASK_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i) |-> (mask_o == $past(wdata_i))); // R2
  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> $stable(mask_o)); // R2
endmodule

// File: rtl/pirq_status.sv
module pirq_status #(
  parameter int unsigned        NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] LATCHED = 32'h0000_0C00
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] status_o
);
  // Write data on live positions is discarded on purpose
  logic unused_live_wdata;
  assign unused_live_wdata = ^(wdata_i & ~LATCHED);

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    if (LATCHED[b]) begin : g_latched
      logic prev_q;
      logic held_q;
      logic rise;
      logic clr_hit;

      assign rise    = src_i[b] & ~prev_q;
      assign clr_hit = clr_wr_i & wdata_i[b];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b0;
          held_q <= 1'b0;
        end else begin
          prev_q <= src_i[b];
          // edge capture has priority over a clearing write
          held_q <= rise | (held_q & ~clr_hit);
        end
      end

      assign status_o[b] = held_q;

      AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(status_o[b]) && !$past(clr_wr_i && wdata_i[b])) |-> status_o[b]); // R5
      AST_LATCH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(clr_wr_i && wdata_i[b]) && !$past(src_i[b])) |-> !status_o[b]); // R4
      AST_LATCH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(src_i[b]) |=> status_o[b]); // R5
    end else begin : g_live
      assign status_o[b] = src_i[b];
    end
  end
endmodule

// File: rtl/pirq_lowest.sv
module pirq_lowest #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  logic [NUM_SRC-1:0] below;
  assign below = (NUM_SRC'(1) << idx_o) - NUM_SRC'(1);

  always_comb begin
    if (valid_o) begin
      AST_IDX_PENDING: assert (req_i[idx_o]); // R7
      AST_NONE_BELOW: assert ((req_i & below) == '0); // R7
    end else begin
      AST_EMPTY_REQ: assert (req_i == '0); // R7
    end
  end
endmodule

// File: rtl/pirq_aggregator.sv
module pirq_aggregator
  import pirq_pkg::*;
#(
  parameter int unsigned        NUM_SRC = DEF_NUM_SRC,
  parameter logic [NUM_SRC-1:0] LATCHED = DEF_LATCHED,
  parameter int unsigned        ADDR_W  = 4,
  localparam int unsigned       IDX_W   = $clog2(NUM_SRC),
  localparam int unsigned       VLD_BIT = NUM_SRC - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  output logic               irq_o
);
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] pending;
  logic               vec_valid;
  logic [IDX_W-1:0]   vec_idx;
  logic [NUM_SRC-1:0] vec_word;
  logic [NUM_SRC-1:0] rdata_q;

  always_comb begin
    if (reg_addr_i == ADDR_W'(ADDR_MASK))        sel = SEL_MASK;
    else if (reg_addr_i == ADDR_W'(ADDR_STATUS)) sel = SEL_STATUS;
    else if (reg_addr_i == ADDR_W'(ADDR_VECTOR)) sel = SEL_VECTOR;
    else                                         sel = SEL_NONE;
  end

  pirq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i && (sel == SEL_MASK)),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask)
  );

  pirq_status #(.NUM_SRC(NUM_SRC), .LATCHED(LATCHED)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .clr_wr_i (reg_wr_i && (sel == SEL_STATUS)),
    .wdata_i  (reg_wdata_i),
    .status_o (status)
  );

  assign pending = status & mask;
  assign irq_o   = |pending;

  pirq_lowest #(.NUM_SRC(NUM_SRC)) u_lowest (
    .req_i   (pending),
    .valid_o (vec_valid),
    .idx_o   (vec_idx)
  );

  always_comb begin
    vec_word              = '0;
    vec_word[IDX_W-1:0]   = vec_idx;
    vec_word[VLD_BIT]     = vec_valid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      unique case (sel)
        SEL_MASK:   rdata_q <= mask;
        SEL_STATUS: rdata_q <= status;
        SEL_VECTOR: rdata_q <= vec_word;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;

  AST_IRQ_VEC_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == vec_valid); // R3
  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_rd_i && (sel == SEL_NONE)) |-> (reg_rdata_o == '0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_rd_i) |-> $stable(reg_rdata_o)); // R2
endmodule

// File: tb/test_pirq_aggregator.sv
module test_pirq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] LATCH_BITS = 32'h0000_0C00;
  localparam logic [31:0] VALID = 32'h8000_0000;

  always #2 clk = ~clk;

  pirq_aggregator i_pirq_aggregator (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_i       (src),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] lowest_vec(input logic [31:0] p);
    logic [31:0] v = '0;
    for (int i = 31; i >= 0; i--) begin
      if (p[i]) v = VALID | 32'(i);
    end
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lcg;
    logic [31:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    reg_read(4'h0, d); chk("R1 mask", d, 32'h0);
    reg_read(4'h4, d); chk("R1 status", d, 32'h0);
    reg_read(4'h8, d); chk("R1 vector", d, 32'h0);

    // R2 mask write/read sweep
    for (int i = 0; i < 32; i++) begin
      pat = (32'h1 << i) ^ (32'hA5A5_0000 >> i);
      reg_write(4'h0, pat);
      reg_read(4'h0, d); chk("R2 mask readback", d, pat);
    end

    // R9 unmapped addresses
    foreach (pat[k]) begin
      if (k < 16 && k != 0 && k != 4 && k != 8) begin
        reg_read(4'(k), d); chk("R9 unmapped", d, 32'h0);
      end
    end

    // single live sources: R6, R8, R3, R7
    for (int i = 0; i < 32; i++) begin
      if (!LATCH_BITS[i]) begin
        reg_write(4'h0, 32'h0);
        src = 32'h1 << i;
        #1;
        chk("R8 masked irq", {31'b0, irq}, 32'h0);
        reg_read(4'h8, d); chk("R8 masked vector", d, 32'h0);
        reg_read(4'h4, d); chk("R6 live status", d, 32'h1 << i);
        reg_write(4'h0, 32'h1 << i);
        chk("R3 irq on", {31'b0, irq}, 32'h1);
        reg_read(4'h8, d); chk("R7 vector", d, VALID | 32'(i));
        src = '0;
        #1;
        chk("R3 irq follows level", {31'b0, irq}, 32'h0);
        @(negedge clk);
      end
    end

    // mixtures with mixed masks: R3, R7, R6
    lcg = 32'h1234_5678;
    for (int n = 0; n < 200; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      pat = lcg & ~LATCH_BITS;
      if (n % 4 == 0) pat = pat & (32'hFFFF_FFFF << (n % 32));
      src = pat;
      d = (n % 3 == 0) ? (lcg ^ 32'h5A5A_A5A5) : 32'hFFFF_FFFF;
      reg_write(4'h0, d);
      chk("R3 irq mix", {31'b0, irq}, {31'b0, |(pat & d)});
      reg_read(4'h8, d); chk("R7 lowest", d, lowest_vec(pat & ((n % 3 == 0) ? (lcg ^ 32'h5A5A_A5A5) : 32'hFFFF_FFFF)));
      if (n % 10 == 0) begin
        reg_write(4'h4, 32'hFFFF_FFFF);
        reg_read(4'h4, d); chk("R6 write ignored", d, pat);
      end
    end
    src = '0;
    @(negedge clk);

    // latched events: R4, R5
    for (int b = 10; b < 12; b++) begin
      reg_write(4'h0, 32'h1 << b);
      src[b] = 1'b1;
      @(negedge clk);
      src[b] = 1'b0;
      @(negedge clk);
      chk("R4 latched irq", {31'b0, irq}, 32'h1);
      reg_read(4'h4, d); chk("R4 latched status", d, 32'h1 << b);
      reg_read(4'h8, d); chk("R4 latched vector", d, VALID | 32'(b));
      reg_write(4'h4, ~(32'h1 << b));
      reg_read(4'h4, d); chk("R5 zero write keeps", d, 32'h1 << b);
      reg_write(4'h4, 32'h1 << b);
      reg_read(4'h4, d); chk("R4 cleared", d, 32'h0);
      chk("R4 irq after clear", {31'b0, irq}, 32'h0);
      // held level does not re-set after a clear
      src[b] = 1'b1;
      @(negedge clk);
      reg_write(4'h4, 32'h1 << b);
      @(negedge clk);
      reg_read(4'h4, d); chk("R4 level no reset", d, 32'h0);
      src[b] = 1'b0;
      @(negedge clk);
      // set wins over a simultaneous clear
      src[b] = 1'b1;
      reg_write(4'h4, 32'h1 << b);
      reg_read(4'h4, d); chk("R5 set wins", d, 32'h1 << b);
      src[b] = 1'b0;
      reg_write(4'h4, 32'h1 << b);
      reg_read(4'h4, d); chk("R4 final clear", d, 32'h0);
    end

    // both latched bits pending: lower index first (R7)
    reg_write(4'h0, 32'hFFFF_FFFF);
    src[11] = 1'b1; @(negedge clk);
    src[10] = 1'b1; @(negedge clk);
    src[11:10] = 2'b00;
    reg_read(4'h8, d); chk("R7 latched priority", d, VALID | 32'd10);
    reg_write(4'h4, 32'h0000_0400);
    reg_read(4'h8, d); chk("R7 after clear", d, VALID | 32'd11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule